// File: doc/BRIEF.md
# Successive-Approximation ADC Controller

This block is the digital half of a 10-bit successive-approximation converter inside a small 4-bit controller. It holds two 4-bit control registers. One picks the analog channel. The other picks the operating mode and the pin functions. A start strobe launches a binary search. The search drives a trial code to an external DAC and reads back an external comparator. When the search ends, the final code is stored in a result register and a completion flag is raised.

The flag can be cleared in two ways. The first is an interrupt acknowledge. The second is a skip-test strobe, which reports whether a skip happened. An enable input decides whether the flag raises an interrupt request or is left for polling. The result is read over a 4-bit datapath. The upper eight bits come out as two nibbles. The lower two bits come out in the top two bits of a third nibble.

A second mode runs a single comparison instead of the full search. It compares the input against the code already held in the result register and returns the one-bit outcome.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After a synchronous reset, both control registers read 0000, the result is 0, the flag is 0 and `busy` is 0.
- R2: A write with `reg_sel`=0 loads the channel register and a write with `reg_sel`=1 loads the mode register. The value is visible one cycle later and all 4 bits read back, including the channel register's unused bit 3. `chan_sel` equals channel register bits 2..0.
- R3: With mode bit 3 = 0, a start runs an MSB-first search. Each trial bit is set, held for `STEP_CYC` cycles, and kept only if `cmp_in` is 1 (input at or above the DAC code). The first trial code is 512, and the stored result is the largest code for which `cmp_in` is 1.
- R4: `busy` rises on the edge that samples the start. The result, the flag and the fall of `busy` all occur on the edge 10·`STEP_CYC`+1 cycles after the start edge.
- R5: A start strobe seen while `busy` is 1 has no effect on the timing or the result of the running operation.
- R6: With mode bit 3 = 1, a start compares `cmp_in` against the current result code after `STEP_CYC` cycles. It places the outcome on `cmp_bit`, sets the flag, ends `busy`, and leaves the result unchanged.
- R7: `irq_req` equals flag AND `irq_en`. An `irq_ack` clears the flag on the next edge.
- R8: A `skip_test` strobe makes `skip_taken` 1 for one cycle if the flag was set, and clears the flag. If completion happens on the same edge as a clear request, the set wins.
- R9: `rd_hi` loads `res_hi_upper` with result bits 9..6 and `res_hi_lower` with result bits 5..2.
- R10: `rd_lo` while idle loads `res_lo` with {result[1:0], 2'b00}. While `busy` is 1, `res_lo` keeps its value and `lo_rd_err` pulses 1 for one cycle.
- R11: While idle, `dac_code` equals the result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = channel register, 1 = mode register |
| wr_data | input | 4 | Write data |
| chan_q | output | 4 | Channel register contents |
| mode_q | output | 4 | Mode register contents (bit 3 = comparator mode) |
| chan_sel | output | 3 | Analog channel select |
| start | input | 1 | Start strobe |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the DAC level |
| dac_code | output | 10 | Code driven to the DAC |
| busy | output | 1 | Operation in progress |
| cmp_bit | output | 1 | Outcome of the last single comparison |
| irq_en | input | 1 | 1 = flag raises an interrupt request |
| irq_ack | input | 1 | Interrupt taken; clears the flag |
| skip_test | input | 1 | Skip-test strobe on the flag |
| done_flag | output | 1 | Completion flag |
| irq_req | output | 1 | Interrupt request |
| skip_taken | output | 1 | Skip-test found the flag set |
| rd_hi | input | 1 | Load the upper result nibbles |
| rd_lo | input | 1 | Load the lower result bits |
| res_hi_upper | output | 4 | Result bits 9..6 |
| res_hi_lower | output | 4 | Result bits 5..2 |
| res_lo | output | 4 | Result bits 1..0 in bits 3..2 |
| lo_rd_err | output | 1 | Low read attempted while busy |

## Verification
The bench builds the block with `STEP_CYC`=3 and leaves the 10-bit resolution at its default. With a multi-cycle settle window, the step counter is really exercised, and an off-by-one in the trial hold time moves the completion edge where the reference model catches it. The full-scale and zero inputs reach both ends of the search. Holding `skip_test` high across a completion reaches the case where set and clear happen on the same edge.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SEARCH  = 2'd1,
    ST_FINISH  = 2'd2,
    ST_COMPARE = 2'd3
  } sar_state_e;

  typedef enum logic {
    SEL_CHAN = 1'b0,
    SEL_MODE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/sar_ctrl_regs.sv
module sar_ctrl_regs #(
  parameter int NIB_W    = 4,
  parameter int NUM_REGS = 2,
  localparam int SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [SEL_W-1:0]                 wr_sel,
  input  logic [NIB_W-1:0]                 wr_data,
  output logic [NUM_REGS-1:0][NIB_W-1:0]   reg_q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        reg_q[g] <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(g))) begin
        reg_q[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/sar_search_seq.sv
module sar_search_seq
  import sar_adc_pkg::*;
#(
  parameter int RES_W    = 10,
  parameter int STEP_CYC = 2,
  localparam int BIT_W   = $clog2(RES_W),
  localparam int CNT_W   = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_mode,
  input  logic             cmp_in,
  output logic             busy,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             done_evt,
  output logic             cmp_bit
);
  localparam logic [CNT_W-1:0] CNT_RELOAD = CNT_W'(STEP_CYC - 1);
  localparam logic [BIT_W-1:0] TOP_BIT    = BIT_W'(RES_W - 1);

  sar_state_e       state;
  logic [RES_W-1:0] work;
  logic [BIT_W-1:0] bit_idx;
  logic [CNT_W-1:0] cnt;
  logic             step_due;

  assign step_due = (cnt == '0);
  assign busy     = (state != ST_IDLE);
  assign dac_code = work;
  assign done_evt = (state == ST_FINISH) || ((state == ST_COMPARE) && step_due);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      work    <= '0;
      result  <= '0;
      bit_idx <= '0;
      cnt     <= '0;
      cmp_bit <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            cnt <= CNT_RELOAD;
            if (cmp_mode) begin
              state <= ST_COMPARE;
            end else begin
              state   <= ST_SEARCH;
              work    <= RES_W'(1) << (RES_W - 1);
              bit_idx <= TOP_BIT;
            end
          end
        end
        ST_SEARCH: begin
          if (!step_due) begin
            cnt <= cnt - 1'b1;
          end else begin
            if (!cmp_in) work[bit_idx] <= 1'b0;
            if (bit_idx == '0) begin
              state <= ST_FINISH;
            end else begin
              work[bit_idx - 1'b1] <= 1'b1;
              bit_idx              <= bit_idx - 1'b1;
              cnt                  <= CNT_RELOAD;
            end
          end
        end
        ST_FINISH: begin
          result <= work;
          state  <= ST_IDLE;
        end
        ST_COMPARE: begin
          if (!step_due) begin
            cnt <= cnt - 1'b1;
          end else begin
            cmp_bit <= cmp_in;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_done_flag.sv
module sar_done_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic irq_en,
  input  logic irq_ack,
  input  logic skip_test,
  output logic flag,
  output logic irq_req,
  output logic skip_taken
);
  assign irq_req = flag & irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag       <= 1'b0;
      skip_taken <= 1'b0;
    end else begin
      skip_taken <= skip_test & flag;
      if (set_evt) begin
        flag <= 1'b1;
      end else if (irq_ack || skip_test) begin
        flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sar_result_read.sv
module sar_result_read #(
  parameter int RES_W  = 10,
  parameter int NIB_W  = 4,
  localparam int LO_W  = RES_W - 2 * NIB_W,
  localparam int PAD_W = NIB_W - LO_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [RES_W-1:0]          result,
  input  logic                      busy,
  input  logic                      rd_hi,
  input  logic                      rd_lo,
  output logic [1:0][NIB_W-1:0]     hi_nib,
  output logic [NIB_W-1:0]          lo_nib,
  output logic                      lo_err
);
  for (genvar k = 0; k < 2; k++) begin : g_hi
    always_ff @(posedge clk) begin
      if (rst) begin
        hi_nib[k] <= '0;
      end else if (rd_hi) begin
        hi_nib[k] <= result[LO_W + k * NIB_W +: NIB_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_nib <= '0;
      lo_err <= 1'b0;
    end else begin
      lo_err <= rd_lo & busy;
      if (rd_lo && !busy) begin
        lo_nib <= {result[LO_W-1:0], {PAD_W{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int RES_W    = 10,
  parameter int NIB_W    = 4,
  parameter int CH_W     = 3,
  parameter int STEP_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [NIB_W-1:0] wr_data,
  output logic [NIB_W-1:0] chan_q,
  output logic [NIB_W-1:0] mode_q,
  output logic [CH_W-1:0]  chan_sel,
  input  logic             start,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             busy,
  output logic             cmp_bit,
  input  logic             irq_en,
  input  logic             irq_ack,
  input  logic             skip_test,
  output logic             done_flag,
  output logic             irq_req,
  output logic             skip_taken,
  input  logic             rd_hi,
  input  logic             rd_lo,
  output logic [NIB_W-1:0] res_hi_upper,
  output logic [NIB_W-1:0] res_hi_lower,
  output logic [NIB_W-1:0] res_lo,
  output logic             lo_rd_err
);
  localparam int MODE_BIT = NIB_W - 1;

  logic [1:0][NIB_W-1:0] regs;
  logic [1:0][NIB_W-1:0] hi_nib;
  logic [RES_W-1:0]      result;
  logic                  done_evt;

  sar_ctrl_regs #(.NIB_W(NIB_W), .NUM_REGS(2)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_sel(reg_sel),
    .wr_data(wr_data), .reg_q(regs)
  );

  assign chan_q   = regs[SEL_CHAN];
  assign mode_q   = regs[SEL_MODE];
  assign chan_sel = chan_q[CH_W-1:0];

  sar_search_seq #(.RES_W(RES_W), .STEP_CYC(STEP_CYC)) u_seq (
    .clk(clk), .rst(rst), .start(start), .cmp_mode(mode_q[MODE_BIT]),
    .cmp_in(cmp_in), .busy(busy), .dac_code(dac_code), .result(result),
    .done_evt(done_evt), .cmp_bit(cmp_bit)
  );

  sar_done_flag u_flag (
    .clk(clk), .rst(rst), .set_evt(done_evt), .irq_en(irq_en),
    .irq_ack(irq_ack), .skip_test(skip_test), .flag(done_flag),
    .irq_req(irq_req), .skip_taken(skip_taken)
  );

  sar_result_read #(.RES_W(RES_W), .NIB_W(NIB_W)) u_read (
    .clk(clk), .rst(rst), .result(result), .busy(busy), .rd_hi(rd_hi),
    .rd_lo(rd_lo), .hi_nib(hi_nib), .lo_nib(res_lo), .lo_err(lo_rd_err)
  );

  assign res_hi_upper = hi_nib[1];
  assign res_hi_lower = hi_nib[0];
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic             reg_sel,
  input logic [NIB_W-1:0] wr_data,
  input logic [NIB_W-1:0] chan_q,
  input logic             start,
  input logic             busy,
  input logic             irq_ack,
  input logic             skip_test,
  input logic             done_flag,
  input logic             skip_taken,
  input logic             rd_lo,
  input logic [NIB_W-1:0] res_lo,
  input logic             lo_rd_err
);
  AST_CHAN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(reg_wr) && !$past(reg_sel)) |-> (chan_q == $past(wr_data))); // R2
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy); // R4
  AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done_flag); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !busy) |=> !done_flag); // R7
  AST_SKIP_REPORT: assert property (@(posedge clk) disable iff (rst)
    (skip_test && done_flag) |=> skip_taken); // R8
  AST_LO_BUSY_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && busy) |=> (lo_rd_err && $stable(res_lo))); // R10
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .wr_data(wr_data),
  .chan_q(chan_q), .start(start), .busy(busy), .irq_ack(irq_ack),
  .skip_test(skip_test), .done_flag(done_flag), .skip_taken(skip_taken),
  .rd_lo(rd_lo), .res_lo(res_lo), .lo_rd_err(lo_rd_err)
);

// File: tb/sar_adc_ctrl_bench.sv
module sar_adc_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STEP       = 3;
  localparam int CONV_LEN   = 10 * STEP + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_sel = 0, start = 0, irq_en = 0, irq_ack = 0;
  logic skip_test = 0, rd_hi = 0, rd_lo = 0;
  logic [3:0] wr_data = '0;
  logic [3:0] chan_q, mode_q, res_hi_upper, res_hi_lower, res_lo;
  logic [2:0] chan_sel;
  logic [9:0] dac_code;
  logic busy, cmp_bit, done_flag, irq_req, skip_taken, lo_rd_err, cmp_in;
  int vin = 0;
  int n_cmp = 0, n_bad = 0;
  bit armed = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign cmp_in = (vin >= int'(dac_code));

  sar_adc_ctrl #(.STEP_CYC(STEP)) u_sar_adc_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .wr_data(wr_data),
    .chan_q(chan_q), .mode_q(mode_q), .chan_sel(chan_sel), .start(start),
    .cmp_in(cmp_in), .dac_code(dac_code), .busy(busy), .cmp_bit(cmp_bit),
    .irq_en(irq_en), .irq_ack(irq_ack), .skip_test(skip_test),
    .done_flag(done_flag), .irq_req(irq_req), .skip_taken(skip_taken),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .res_hi_upper(res_hi_upper),
    .res_hi_lower(res_hi_lower), .res_lo(res_lo), .lo_rd_err(lo_rd_err)
  );

  // Behavioural reference model
  logic [3:0] m_chan = 0, m_mode = 0, m_hib = 0, m_hia = 0, m_lo = 0;
  logic [9:0] m_res = 0;
  bit m_busy = 0, m_conv = 0, m_flag = 0, m_skip = 0, m_err = 0, m_cbit = 0;
  int m_rem = 0;

  always @(posedge clk) begin
    logic [9:0] o_res;
    bit o_busy, o_flag, done;
    o_res = m_res; o_busy = m_busy; o_flag = m_flag;
    armed = 1;
    if (rst) begin
      m_chan = 0; m_mode = 0; m_hib = 0; m_hia = 0; m_lo = 0; m_res = 0;
      m_busy = 0; m_flag = 0; m_skip = 0; m_err = 0; m_cbit = 0; m_rem = 0;
    end else begin
      done = 0;
      if (m_busy) begin
        m_rem--;
        if (m_rem == 0) begin
          m_busy = 0; done = 1;
          if (m_conv) m_res = vin[9:0];
          else m_cbit = (vin >= int'(o_res));
        end
      end else if (start) begin
        m_busy = 1; m_conv = !m_mode[3];
        m_rem = m_conv ? CONV_LEN : STEP;
      end
      m_skip = skip_test && o_flag;
      if (done) m_flag = 1;
      else if (irq_ack || skip_test) m_flag = 0;
      if (reg_wr) begin
        if (reg_sel) m_mode = wr_data; else m_chan = wr_data;
      end
      if (rd_hi) begin m_hib = o_res[9:6]; m_hia = o_res[5:2]; end
      m_err = rd_lo && o_busy;
      if (rd_lo && !o_busy) m_lo = {o_res[1:0], 2'b00};
    end
  end

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", rq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      chk("R2", "chan_q", 32'(chan_q), 32'(m_chan));
      chk("R2", "mode_q", 32'(mode_q), 32'(m_mode));
      chk("R2", "chan_sel", 32'(chan_sel), 32'(m_chan[2:0]));
      chk("R4", "busy", 32'(busy), 32'(m_busy));
      chk("R7", "done_flag", 32'(done_flag), 32'(m_flag));
      chk("R7", "irq_req", 32'(irq_req), 32'(m_flag & irq_en));
      chk("R8", "skip_taken", 32'(skip_taken), 32'(m_skip));
      chk("R6", "cmp_bit", 32'(cmp_bit), 32'(m_cbit));
      chk("R9", "res_hi_upper", 32'(res_hi_upper), 32'(m_hib));
      chk("R9", "res_hi_lower", 32'(res_hi_lower), 32'(m_hia));
      chk("R10", "res_lo", 32'(res_lo), 32'(m_lo));
      chk("R10", "lo_rd_err", 32'(lo_rd_err), 32'(m_err));
      if (!m_busy) chk("R11", "idle dac_code", 32'(dac_code), 32'(m_res));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(bit sel, logic [3:0] d);
    reg_wr = 1; reg_sel = sel; wr_data = d; tick(); reg_wr = 0;
  endtask

  task automatic conv(int v, bit trace);
    vin = v; start = 1; tick(); start = 0;
    if (trace) begin
      @(negedge clk);
      chk("R3", "first trial", 32'(dac_code), 32'd512);
      tick(STEP);
      @(negedge clk);
      chk("R3", "second trial", 32'(dac_code), 32'((v >= 512 ? 512 : 0) + 256));
      tick(CONV_LEN + 2 - STEP);
    end else begin
      tick(CONV_LEN + 2);
    end
  endtask

  initial begin
    tick(3);
    rst = 0;
    @(negedge clk);
    chk("R1", "reset chan", 32'(chan_q), 0);
    chk("R1", "reset mode", 32'(mode_q), 0);
    chk("R1", "reset dac", 32'(dac_code), 0);
    chk("R1", "reset flag", 32'(done_flag), 0);
    chk("R1", "reset busy", 32'(busy), 0);
    tick();
    wr_reg(0, 4'b1011);
    wr_reg(1, 4'b0101);
    wr_reg(1, 4'b0000);
    conv(700, 1);
    rd_hi = 1; rd_lo = 1; tick(); rd_hi = 0; rd_lo = 0;
    skip_test = 1; tick(); skip_test = 0; tick();
    skip_test = 1; tick(); skip_test = 0; tick();
    vin = 333; start = 1; tick(); start = 0; tick(4);
    rd_lo = 1; tick(); rd_lo = 0;
    start = 1; tick(); start = 0;            // R5 start while busy
    tick(CONV_LEN);
    @(negedge clk);
    chk("R5", "busy after run", 32'(busy), 0);
    chk("R3", "result via hi", 32'(res_hi_upper), 32'(700 >> 6));
    rd_hi = 1; rd_lo = 1; tick(); rd_hi = 0; rd_lo = 0;
    @(negedge clk);
    chk("R9", "hi upper 333", 32'(res_hi_upper), 32'(333 >> 6));
    chk("R10", "lo 333", 32'(res_lo), 32'((333 & 3) << 2));
    conv(0, 1);
    conv(1023, 1);
    rd_hi = 1; rd_lo = 1; tick(); rd_hi = 0; rd_lo = 0;
    conv(512, 1);
    irq_en = 1;
    conv(100, 0);
    irq_ack = 1; tick(); irq_ack = 0; tick(2);
    irq_en = 0;
    wr_reg(1, 4'b1000);                      // R6 comparator mode
    conv(400, 0);
    conv(50, 0);
    @(negedge clk);
    chk("R6", "result unchanged", 32'(dac_code), 32'd100);
    wr_reg(1, 4'b0000);
    skip_test = 1;                           // R8 set wins over clear
    conv(901, 0);
    skip_test = 0; tick(2);
    rd_hi = 1; rd_lo = 1; tick(); rd_hi = 0; rd_lo = 0;
    tick(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule